// File: doc/BRIEF.md
# Banked Interrupt Controller with End-of-Interrupt Clearing

This block gathers up to 48 interrupt sources, arranged as three banks of sixteen, and presents them to a processor through a small register bus. Each bank has a status register that shows the raw request of every implemented source and a mask register in which a 1 enables a source. Some sources are edge-latched: a rising input edge sets their request, which is held until software writes any value to that source's private end-of-interrupt address. All other sources are level-sensitive, and their status follows the input pin directly.

Every enabled, requesting source is routed to one of two processor lines. Three sources drive the fast line (`fiq_o`). All others drive the normal line (`irq_o`). A helper output names the source that software should service first: bank 1 is searched before bank 2, and bank 2 before bank 3. Within a bank, the highest bit number wins. All outputs are registered. Reads are combinational from the address.

Top module: `banked_intc`

## Requirements
- R1: After reset, all mask bits and all latched requests are 0, and `irq_o`, `fiq_o`, `top_valid` and `top_idx` are 0.
- R2: The mask registers are at byte address 0x0280 (bank 1, sources 0-15), 0x1280 (bank 2, sources 16-31) and 0x2280 (bank 3, sources 32-47). Source n is bit n%16 of bank n/16. Implemented bits read back exactly as written. The implemented sources are 1, 3-18, 28, 29 and 32. Unimplemented bits read 0, so writing 0xFFFF reads back 0xFFFA, 0x3007 and 0x0001.
- R3: The status registers are at 0x0240, 0x1240 and 0x2240, with the same bit layout as the mask registers. A level source's status bit equals its input in the same cycle. Writes to status addresses are ignored. Reads of end-of-interrupt addresses, and of any unmapped address, return 0.
- R4: The latched sources are 1, 3, 4, 8, 9, 10, 11, 14, 15 and 16. A rising edge on one of their inputs sets its status bit on the next clock. The bit stays set after the input falls.
- R5: A write of any data to a source's end-of-interrupt address clears that source's latched status on that clock. The addresses are 0x0600 (source 1), 0x0640 (3), 0x07C0 (4), 0x06C0 (8), 0x0700 (9), 0x0740 (10), 0x0680 (11), 0x0780 (14), 0x1600 (15) and 0x1700 (16).
- R6: When a rising edge and an end-of-interrupt write for the same source fall on the same clock, the status bit remains set.
- R7: `irq_o` is registered. It is the OR of all sources that are pending (status and mask both 1) and not fast.
- R8: Sources 1, 3 and 32 are fast. When pending, they assert the registered `fiq_o` and never `irq_o`.
- R9: `top_valid` is registered and is 1 when any source is pending. `top_idx` is registered and gives the source number chosen as follows: the lowest-numbered bank that has a pending source, then the highest pending bit within that bank.
- R10: A masked source still shows in its status register. It affects none of `irq_o`, `fiq_o`, `top_valid` or `top_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 14 | Byte address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| src_in | input | 48 | Interrupt source inputs, bit n is source n |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| top_valid | output | 1 | Some source is pending |
| top_idx | output | 6 | Number of the source to service first |

## Verification
The assertions check the following on every cycle:
- Latched requests hold until their end-of-interrupt write.
- An end-of-interrupt write with no coincident edge clears the request.
- A rising edge always sets the request.
- A level source's status follows its pin.
- A pending source reaches its line one clock later.
- The helper never names a later bank while an earlier bank has a pending source.

Only the bench scenarios show the following:
- Exact read-back values after writes, including unimplemented bits.
- That status writes are ignored.
- The full search order across banks, and that masked sources stay silent while their status is still visible.

// File: rtl/banked_intc.sv
module banked_intc #(
  parameter int NBANK = 3,
  parameter int BANK_W = 16,
  parameter int ADDR_W = 14,
  parameter int STAT_OFS = 'h0240,
  parameter int MASK_OFS = 'h0280,
  parameter int BANK_STRIDE = 'h1000,
  parameter logic [NBANK*BANK_W-1:0] USED_SRC = 48'h0001_3007_FFFA,
  parameter logic [NBANK*BANK_W-1:0] LATCH_SRC = 48'h0000_0001_CF1A,
  parameter logic [NBANK*BANK_W-1:0] FAST_SRC = 48'h0001_0000_000A
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_wr,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [BANK_W-1:0]                 bus_wdata,
  output logic [BANK_W-1:0]                 bus_rdata,
  input  logic [NBANK*BANK_W-1:0]           src_in,
  output logic                              irq_o,
  output logic                              fiq_o,
  output logic                              top_valid,
  output logic [$clog2(NBANK*BANK_W)-1:0]   top_idx
);
  localparam int NSRC = NBANK * BANK_W;
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0] lat_q, prev_q, mask_q;
  logic [NSRC-1:0] status, pend, eoi_hit;
  logic            sel_hit;
  logic [IDX_W-1:0] sel_idx;

  function automatic logic [NSRC-1:0] eoi_decode(input logic [ADDR_W-1:0] a);
    logic [NSRC-1:0] v;
    v = '0;
    case (a)
      ADDR_W'('h0600): v[1]  = 1'b1;
      ADDR_W'('h0640): v[3]  = 1'b1;
      ADDR_W'('h07C0): v[4]  = 1'b1;
      ADDR_W'('h06C0): v[8]  = 1'b1;
      ADDR_W'('h0700): v[9]  = 1'b1;
      ADDR_W'('h0740): v[10] = 1'b1;
      ADDR_W'('h0680): v[11] = 1'b1;
      ADDR_W'('h0780): v[14] = 1'b1;
      ADDR_W'('h1600): v[15] = 1'b1;
      ADDR_W'('h1700): v[16] = 1'b1;
      default: v = '0;
    endcase
    return v & LATCH_SRC;
  endfunction

  assign eoi_hit = bus_wr ? eoi_decode(bus_addr) : '0;
  assign status  = ((LATCH_SRC & lat_q) | (~LATCH_SRC & src_in)) & USED_SRC;
  assign pend    = status & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= src_in;
      lat_q  <= ((lat_q & ~eoi_hit) | (src_in & ~prev_q)) & LATCH_SRC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (bus_wr) begin
      for (int b = 0; b < NBANK; b++)
        if (bus_addr == ADDR_W'(MASK_OFS + b * BANK_STRIDE))
          mask_q[b*BANK_W +: BANK_W] <= bus_wdata & USED_SRC[b*BANK_W +: BANK_W];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == ADDR_W'(STAT_OFS + b * BANK_STRIDE))
        bus_rdata = status[b*BANK_W +: BANK_W];
      if (bus_addr == ADDR_W'(MASK_OFS + b * BANK_STRIDE))
        bus_rdata = mask_q[b*BANK_W +: BANK_W];
    end
  end

  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    for (int b = NBANK - 1; b >= 0; b--)
      for (int i = 0; i < BANK_W; i++)
        if (pend[b*BANK_W + i]) begin
          sel_hit = 1'b1;
          sel_idx = IDX_W'(b * BANK_W + i);
        end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
      top_valid <= 1'b0;
      top_idx   <= '0;
    end else begin
      irq_o     <= |(pend & ~FAST_SRC);
      fiq_o     <= |(pend & FAST_SRC);
      top_valid <= sel_hit;
      top_idx   <= sel_idx;
    end
  end
endmodule

// File: rtl/banked_intc_chk.sv
module banked_intc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [13:0] bus_addr,
  input logic [15:0] bus_rdata,
  input logic [47:0] src_in,
  input logic        irq_o,
  input logic        fiq_o,
  input logic        top_valid,
  input logic [5:0]  top_idx,
  input logic [47:0] lat_q,
  input logic [47:0] prev_q,
  input logic [47:0] pend
);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q[1] && !(bus_wr && bus_addr == 14'h0600)) |=> lat_q[1]);
  p_eoi_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 14'h06C0 && !(src_in[8] && !prev_q[8])) |=> !lat_q[8]);
  p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_in[9] && !prev_q[9]) |=> lat_q[9]);
  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 14'h0240) |-> (bus_rdata[5] == src_in[5]));
  p_irq_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend[5] |=> irq_o);
  p_fiq_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[1] || pend[32]) |=> fiq_o);
  p_valid_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
    top_valid |-> (irq_o || fiq_o));
  p_bank_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend[15:0]) |=> (top_valid && top_idx < 6'd16));
endmodule

bind banked_intc banked_intc_chk u_chk (.*);

// File: tb/tb_banked_intc.sv
`timescale 1ns/1ps
module tb_banked_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [47:0] src_in = '0;
  logic        irq_o, fiq_o, top_valid;
  logic [5:0]  top_idx;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  banked_intc dut (.*);

  // {src[47:0], irq, fiq, valid, idx[5:0]}; level sources only
  localparam logic [56:0] VEC [7] = '{
    {48'h0,             1'b0, 1'b0, 1'b0, 6'd0},
    {48'h0000_0000_0020, 1'b1, 1'b0, 1'b1, 6'd5},
    {48'h0000_0000_1020, 1'b1, 1'b0, 1'b1, 6'd12},
    {48'h0000_2002_0000, 1'b1, 1'b0, 1'b1, 6'd29},
    {48'h0000_2000_0020, 1'b1, 1'b0, 1'b1, 6'd5},
    {48'h0001_0000_0000, 1'b0, 1'b1, 1'b1, 6'd32},
    {48'h0001_0004_0000, 1'b1, 1'b1, 1'b1, 6'd18}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [15:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #0.5;
  endtask

  initial begin
    #300000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    rd(14'h0280, d); chk("R1 mask0", d, 0);
    rd(14'h0240, d); chk("R1 status0", d, 0);
    chk("R1 outputs", {irq_o, fiq_o, top_valid, top_idx}, 0);

    // R2 mask readback
    wr(14'h0280, 16'hFFFF); wr(14'h1280, 16'hFFFF); wr(14'h2280, 16'hFFFF);
    rd(14'h0280, d); chk("R2 bank1", d, 16'hFFFA);
    rd(14'h1280, d); chk("R2 bank2", d, 16'h3007);
    rd(14'h2280, d); chk("R2 bank3", d, 16'h0001);
    wr(14'h1280, 16'h0005);
    rd(14'h1280, d); chk("R2 partial", d, 16'h0005);
    wr(14'h1280, 16'hFFFF);

    // R7 R8 R9 vector walk
    for (int k = 0; k < 7; k++) begin
      @(negedge clk); src_in = VEC[k][56:9];
      settle();
      chk($sformatf("R7 irq v%0d", k), irq_o, VEC[k][8]);
      chk($sformatf("R8 fiq v%0d", k), fiq_o, VEC[k][7]);
      chk($sformatf("R9 sel v%0d", k), {top_valid, top_idx}, VEC[k][6:0]);
    end
    @(negedge clk); src_in = '0;

    // R3 level status, ignored status write, EOI read
    @(negedge clk); src_in[5] = 1'b1; src_in[29] = 1'b1;
    #0.5;
    rd(14'h0240, d); chk("R3 level bank1", d, 16'h0020);
    rd(14'h1240, d); chk("R3 level bank2", d, 16'h2000);
    @(negedge clk); src_in = '0;
    wr(14'h0240, 16'hFFFF);
    rd(14'h0240, d); chk("R3 status write ignored", d, 0);
    rd(14'h0600, d); chk("R3 eoi read", d, 0);

    // R10 masked source
    wr(14'h0280, 16'h0000);
    @(negedge clk); src_in[5] = 1'b1;
    settle();
    chk("R10 outputs quiet", {irq_o, fiq_o, top_valid}, 0);
    rd(14'h0240, d); chk("R10 status visible", d, 16'h0020);
    @(negedge clk); src_in = '0;
    wr(14'h0280, 16'hFFFF);

    // R4 latched edge held
    @(negedge clk); src_in[8] = 1'b1;
    @(negedge clk); src_in[8] = 1'b0;
    settle();
    rd(14'h0240, d); chk("R4 latched held", d, 16'h0100);
    chk("R4 irq", {irq_o, top_valid, top_idx}, {1'b1, 1'b1, 6'd8});

    // R5 EOI clears
    wr(14'h06C0, 16'h1234);
    settle();
    rd(14'h0240, d); chk("R5 cleared", d, 0);
    chk("R5 irq low", irq_o, 0);

    // R6 edge and EOI together
    @(negedge clk); src_in[9] = 1'b1; bus_addr = 14'h0700; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    settle();
    rd(14'h0240, d); chk("R6 edge wins", d, 16'h0200);
    wr(14'h0700, 16'h0000);
    settle();
    rd(14'h0240, d); chk("R5 eoi while high", d, 0);
    @(negedge clk); src_in = '0;

    // R8 latched fast source
    @(negedge clk); src_in[1] = 1'b1;
    @(negedge clk); src_in[1] = 1'b0;
    settle();
    chk("R8 fast latched", {irq_o, fiq_o, top_valid, top_idx}, {1'b0, 1'b1, 1'b1, 6'd1});
    wr(14'h0600, 16'hABCD);
    settle();
    chk("R8 fast cleared", {fiq_o, top_valid}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule